// File: doc/BRIEF.md
# Hot-plug detect interrupt unit

This block watches the hot-plug detect line of a display transmitter and turns its settled level changes into interrupt events. The line comes in asynchronous to the local clock. It passes through a multi-flop synchronizer and then through a programmable glitch filter. The filter accepts a new level only after the line has held that level for a programmed number of cycles. Each accepted rising level latches a rise event, and each accepted falling level latches a fall event. A level-sensitive interrupt from the neighbouring transmitter core is latched into the same status word. A single interrupt output goes high while any latched source is also enabled.

Software uses a plain strobe register port. It programs the filter length, reads the filtered level, reads the latched events, clears events by writing ones, and sets an active-high enable mask. The usual bring-up has two steps: clear the rise and fall bits, then enable them.

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset, the filter register reads 0x0000A0A0, the raw, status and mask registers read 0, and irq_o is low.
- R2: With the effective length N = lo << exp (N = 0 treated as 1), a level change on hpd_i that then holds steady sets its enabled event so that irq_o is still low after N+2 rising clock edges and high after N+3 edges.
- R3: A pulse on hpd_i shorter than N cycles changes neither the filtered level nor any status bit.
- R4: Register address 1 (raw) reads 1 in bit 0 when the filtered level is high and reads 0 otherwise.
- R5: An accepted rising level sets status bit 1. An accepted falling level sets status bit 2. Status is at address 2.
- R6: Each cycle on which core_irq_i is high sets status bit 0, and the bit stays set after the input drops.
- R7: Writing to address 3 clears each status bit whose write-data bit is 1. Bits written 0 are unaffected. Address 3 reads 0.
- R8: When a status bit is set and cleared in the same cycle, the bit ends up set.
- R9: The mask at address 4, bits 2:0, is active high, and irq_o is the OR of status AND mask. A masked source still latches its status bit.
- R10: The filter register at address 0 holds the exponent in bits 15:12 and the low count in bits 7:0. All other bits read 0.
- R11: rdata_o loads the addressed register on the clock edge at which rd_en_i is high and holds its value otherwise. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hpd_i | input | 1 | Asynchronous hot-plug detect level |
| core_irq_i | input | 1 | Level interrupt from the transmitter core |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Merged interrupt output |

## Verification
The write-one-to-clear path and the event set path can act on the same status bit in the same cycle. The bench provokes this on the core bit: it holds core_irq_i high for exactly the edge that carries a clear write of bit 0. It then reads status back and expects bit 0 to still be set. The clear on its own is also tested, so the set-wins result cannot hide a clear that does nothing. The filter timing is judged to the exact edge for several exponent and low-count pairs, including a zero count.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
  localparam int unsigned NSRC     = 3;
  localparam int unsigned SRC_CORE = 0;
  localparam int unsigned SRC_RISE = 1;
  localparam int unsigned SRC_FALL = 2;

  localparam int unsigned A_FILT = 0;
  localparam int unsigned A_RAW  = 1;
  localparam int unsigned A_STAT = 2;
  localparam int unsigned A_CLR  = 3;
  localparam int unsigned A_MASK = 4;

  localparam int unsigned EXP_LSB = 12;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/hpd_glitch_filter.sv
module hpd_glitch_filter #(
  parameter int unsigned EXP_W = 4,
  parameter int unsigned LO_W  = 8,
  localparam int unsigned CNT_W = LO_W + (1 << EXP_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [LO_W-1:0]  lo_i,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thresh;
  logic [CNT_W:0]   cnt_inc;
  logic             done;

  assign thresh  = CNT_W'(lo_i) << exp_i;
  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  // zero length behaves as one cycle
  assign done    = cnt_inc >= {1'b0, thresh};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= 1'b0;
      cnt_q   <= '0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (in_i == level_o) begin
        cnt_q <= '0;
      end else if (done) begin
        level_o <= in_i;
        cnt_q   <= '0;
        rise_o  <= in_i;
        fall_o  <= ~in_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R5
  rise_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (level_o && !$past(level_o)));
  // R5
  fall_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!level_o && $past(level_o)));
  // R3
  lvl_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o)) |-> ($past(in_i) == level_o));
endmodule

// File: rtl/hpd_irq_regs.sv
module hpd_irq_regs
  import hpd_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned LO_W    = 8,
  parameter int unsigned RST_EXP = 10,
  parameter int unsigned RST_LO  = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              level_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [LO_W-1:0]   lo_o,
  output logic              irq_o
);
  logic [NSRC-1:0]   stat_q, mask_q, set_vec, clr_vec;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_CORE] = core_i;
    set_vec[SRC_RISE] = rise_i;
    set_vec[SRC_FALL] = fall_i;
  end

  assign clr_vec = (wr_en_i && addr_i == ADDR_W'(A_CLR)) ? wdata_i[NSRC-1:0] : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_stat
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         bit_q <= 1'b0;
      else if (set_vec[i]) bit_q <= 1'b1;
      else if (clr_vec[i]) bit_q <= 1'b0;
    end
    assign stat_q[i] = bit_q;

    // R8
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_vec[i] |=> stat_q[i]);
    // R7
    clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_vec[i] && !set_vec[i]) |=> !stat_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      exp_o  <= EXP_W'(RST_EXP);
      lo_o   <= LO_W'(RST_LO);
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(A_MASK)) mask_q <= wdata_i[NSRC-1:0];
      if (addr_i == ADDR_W'(A_FILT)) begin
        exp_o <= wdata_i[EXP_LSB +: EXP_W];
        lo_o  <= wdata_i[LO_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(A_FILT)) begin
      rd_mux[EXP_LSB +: EXP_W] = exp_o;
      rd_mux[LO_W-1:0]         = lo_o;
    end else if (addr_i == ADDR_W'(A_RAW)) begin
      rd_mux[0] = level_i;
    end else if (addr_i == ADDR_W'(A_STAT)) begin
      rd_mux[NSRC-1:0] = stat_q;
    end else if (addr_i == ADDR_W'(A_MASK)) begin
      rd_mux[NSRC-1:0] = mask_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign irq_o = |(stat_q & mask_q);

  // R9
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(A_MASK)) |=> (mask_q == $past(wdata_i[NSRC-1:0])));
  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
  import hpd_irq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned EXP_W       = 4,
  parameter int unsigned LO_W        = 8,
  parameter int unsigned RST_EXP     = 10,
  parameter int unsigned RST_LO      = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hpd_i,
  input  logic              core_irq_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             hpd_sync;
  logic             level, rise, fall;
  logic [EXP_W-1:0] cfg_exp;
  logic [LO_W-1:0]  cfg_lo;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hpd_i),
    .q_o    (hpd_sync)
  );

  hpd_glitch_filter #(.EXP_W(EXP_W), .LO_W(LO_W)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_i    (hpd_sync),
    .exp_i   (cfg_exp),
    .lo_i    (cfg_lo),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  hpd_irq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EXP_W(EXP_W), .LO_W(LO_W),
    .RST_EXP(RST_EXP), .RST_LO(RST_LO)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .core_i  (core_irq_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .level_i (level),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .exp_o   (cfg_exp),
    .lo_o    (cfg_lo),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/hpd_irq_unit_tb_top.sv
`timescale 1ns/1ps
module hpd_irq_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hpd_i = 1'b0;
  logic        core_irq_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_i = ~clk_i;

  hpd_irq_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hpd_i(hpd_i), .core_irq_i(core_irq_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // {exp, lo, effective length}
  localparam logic [23:0] VEC [0:4] = '{
    {4'd0, 8'd8, 12'd8},
    {4'd1, 8'd3, 12'd6},
    {4'd2, 8'd1, 12'd4},
    {4'd0, 8'd0, 12'd1},
    {4'd3, 8'd2, 12'd16}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(3'd0, v); chk("R1 filt", v, 32'h0000A0A0);
    rd(3'd1, v); chk("R1 raw", v, 0);
    rd(3'd2, v); chk("R1 stat", v, 0);
    rd(3'd4, v); chk("R1 mask", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);

    // R10 field layout
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R10 fields", v, 32'h0000F0FF);
    // R11 unmapped / clear reads
    rd(3'd7, v); chk("R11 unmapped", v, 0);
    rd(3'd3, v); chk("R7 clr reads 0", v, 0);

    wr(3'd4, 32'h6);
    for (int k = 0; k < 5; k++) begin
      logic [3:0]  e;
      logic [7:0]  l;
      logic [11:0] n;
      {e, l, n} = VEC[k];
      wr(3'd0, {16'b0, e, 4'b0, l});
      rd(3'd0, v); chk("R10 readback", v, {16'b0, e, 4'b0, l});
      // rise
      hpd_i = 1'b1;
      repeat (n + 2) @(posedge clk_i);
      @(negedge clk_i); chk("R2 rise early", {31'b0, irq_o}, 0);
      @(posedge clk_i);
      @(negedge clk_i); chk("R2 rise on time", {31'b0, irq_o}, 1);
      rd(3'd1, v); chk("R4 raw high", v, 1);
      rd(3'd2, v); chk("R5 rise bit", v, 32'h2);
      wr(3'd3, 32'h6);
      rd(3'd2, v); chk("R7 cleared", v, 0);
      chk("R9 irq after clear", {31'b0, irq_o}, 0);
      // fall
      hpd_i = 1'b0;
      repeat (n + 2) @(posedge clk_i);
      @(negedge clk_i); chk("R2 fall early", {31'b0, irq_o}, 0);
      @(posedge clk_i);
      @(negedge clk_i); chk("R2 fall on time", {31'b0, irq_o}, 1);
      rd(3'd1, v); chk("R4 raw low", v, 0);
      rd(3'd2, v); chk("R5 fall bit", v, 32'h4);
      wr(3'd3, 32'h6);
    end

    // R3 glitch shorter than N=8
    wr(3'd0, 32'h0000_0008);
    hpd_i = 1'b1;
    repeat (5) @(negedge clk_i);
    hpd_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk("R3 glitch irq", {31'b0, irq_o}, 0);
    rd(3'd1, v); chk("R3 glitch raw", v, 0);
    rd(3'd2, v); chk("R3 glitch stat", v, 0);

    // R6 / R9 core latch while masked
    wr(3'd4, 32'h0);
    core_irq_i = 1'b1;
    @(negedge clk_i);
    core_irq_i = 1'b0;
    rd(3'd2, v); chk("R6 core latched", v, 32'h1);
    chk("R9 masked irq", {31'b0, irq_o}, 0);
    wr(3'd4, 32'h1);
    chk("R9 enabled irq", {31'b0, irq_o}, 1);
    // R7 zero bits leave status alone
    wr(3'd3, 32'h6);
    rd(3'd2, v); chk("R7 zero bits", v, 32'h1);
    wr(3'd3, 32'h1);
    rd(3'd2, v); chk("R7 clear core", v, 0);
    chk("R7 irq low", {31'b0, irq_o}, 0);

    // R8 set and clear on the same edge
    core_irq_i = 1'b1;
    wr(3'd3, 32'h1);
    core_irq_i = 1'b0;
    rd(3'd2, v); chk("R8 set wins", v, 32'h1);
    wr(3'd3, 32'h1);
    rd(3'd2, v); chk("R8 then clear", v, 0);

    // R11 hold without read strobe
    core_irq_i = 1'b1;
    @(negedge clk_i);
    core_irq_i = 1'b0;
    @(negedge clk_i);
    chk("R11 hold", rdata_o, 0);
    rd(3'd2, v); chk("R11 refresh", v, 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule